// File: doc/BRIEF.md
# Trigger-Aligned PWM Burst Generator

This block emits a fixed burst of PWM periods each time an external trigger pulse rises. The trigger may come from outside the clock domain. The first period starts from the trigger itself. An interval timer starts on that same clock edge and, at the moment each period finishes, launches the next one-shot period. The output never free-runs. Every burst is therefore realigned to the trigger, and no phase error builds up from one trigger to the next.

Two output shapes are available, and the shape is chosen per burst. In pulse mode each period is high for a programmed number of ticks and then low. In gated mode a faster carrier square wave runs during the first period of the burst, and the output stays low for the remaining periods. All timing is set in clock ticks through parameters.

Top module: `trig_burst_pwm`

## Requirements
- R1: While reset is high and on the first clock after it, `pwm_out` and `busy` are 0 and `cycle_idx` is 0.
- R2: A rising edge on `trig_in` starts a burst after a fixed latency. If the first clock edge that samples `trig_in` high is edge E1, then `busy` is 1 from edge E3 onward.
- R3: With `mode_sel` = 0 (pulse mode), `pwm_out` is 1 for the first HIGH_TICKS ticks of each period and 0 for the rest of that PERIOD_TICKS-tick period.
- R4: A burst is BURST_CYCLES back-to-back periods. The timer starts each later period on the same edge that ends the previous one, with no idle tick in between, and `pwm_out` is 0 after the last period.
- R5: `busy` stays 1 for exactly BURST_CYCLES*PERIOD_TICKS clock cycles after the burst start.
- R6: `cycle_idx` gives the number of the current period (0 for the first, 1 for the second) while busy, and reads 0 when idle.
- R7: With `mode_sel` = 1 (gated mode), during period 0 `pwm_out` is 1 for the first CARRIER_TICKS/2 ticks of every CARRIER_TICKS-tick carrier cycle. The carrier phase is 0 at the burst start. In all later periods `pwm_out` is 0.
- R8: A new trigger edge that arrives while a burst is running aborts that burst. A fresh burst then starts from period 0, tick 0, with the latency of R2.
- R9: `mode_sel` is sampled on the burst start edge. Changes to it during a burst have no effect on that burst.
- R10: Holding `trig_in` high for many cycles starts only one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous trigger; a rising edge starts a burst |
| mode_sel | input | 1 | 0 = pulse mode, 1 = gated carrier mode |
| pwm_out | output | 1 | PWM output |
| busy | output | 1 | High while a burst runs |
| cycle_idx | output | $clog2(BURST_CYCLES) (min 1) | Index of the current period |

## Verification
A trigger rise driven just before clock edge E1 is first seen on the outputs after edge E3. The bench therefore treats a burst as started at the falling edge that follows the third rising edge after the trigger was driven. From that point it computes every later output value from the tick count since the start. All inputs are driven, and all outputs compared, on falling clock edges, half a cycle away from the edges where the design changes state. Each comparison thus sees the value settled after exactly the number of edges that the requirement counts. The mode used for a burst is the value that was present on the edge the burst started, and the bench model takes that value too.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_GATED = 1'b1
    } burst_mode_e;

    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tbp_sync_edge.sv
module tbp_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[1:0], async_in};
    end

    assign rise = stage_q[1] & ~stage_q[2];

    // R10
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tbp_interval_timer.sv
module tbp_interval_timer
    import tbp_pkg::*;
#(
    parameter int PERIOD_TICKS = 40,
    parameter int BURST_CYCLES = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic                                mode_in,
    output logic                                run,
    output logic                                restart,
    output logic [cnt_w(BURST_CYCLES)-1:0]      idx,
    output burst_mode_e                         mode_q,
    output logic [cnt_w(PERIOD_TICKS)-1:0]      cnt
);
    localparam int CW = cnt_w(PERIOD_TICKS);
    localparam int IW = cnt_w(BURST_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD_TICKS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(BURST_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            mode_q <= MODE_PULSE;
        end else if (start) begin
            run    <= 1'b1;
            cnt    <= '0;
            idx    <= '0;
            mode_q <= burst_mode_e'(mode_in);
        end else if (run) begin
            if (cnt == CNT_LAST) begin
                cnt <= '0;
                if (idx == IDX_LAST) begin
                    run <= 1'b0;
                    idx <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign restart = run && !start && (cnt == CNT_LAST) && (idx != IDX_LAST);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !start) |=> $stable(mode_q));

    // R6
    idle_index_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (idx == '0));

endmodule

// File: rtl/tbp_oneshot.sv
module tbp_oneshot
    import tbp_pkg::*;
#(
    parameter int PERIOD_TICKS = 40
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            go,
    output logic                            active,
    output logic [cnt_w(PERIOD_TICKS)-1:0]  tick
);
    localparam int CW = cnt_w(PERIOD_TICKS);
    localparam logic [CW-1:0] TICK_LAST = CW'(PERIOD_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            tick   <= '0;
        end else if (go) begin
            active <= 1'b1;
            tick   <= '0;
        end else if (active) begin
            if (tick == TICK_LAST) begin
                active <= 1'b0;
                tick   <= '0;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    // R5
    full_period_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> ($past(tick) == TICK_LAST));

endmodule

// File: rtl/tbp_carrier.sv
module tbp_carrier
    import tbp_pkg::*;
#(
    parameter int CARRIER_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic align,
    output logic carrier_hi
);
    localparam int KW = cnt_w(CARRIER_TICKS);
    localparam logic [KW-1:0] PH_LAST = KW'(CARRIER_TICKS - 1);

    logic [KW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || align)           phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                         phase_q <= phase_q + 1'b1;
    end

    assign carrier_hi = int'(phase_q) < (CARRIER_TICKS / 2);

endmodule

// File: rtl/trig_burst_pwm.sv
module trig_burst_pwm
    import tbp_pkg::*;
#(
    parameter int PERIOD_TICKS  = 40,
    parameter int HIGH_TICKS    = 15,
    parameter int CARRIER_TICKS = 6,
    parameter int BURST_CYCLES  = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               trig_in,
    input  logic                               mode_sel,
    output logic                               pwm_out,
    output logic                               busy,
    output logic [cnt_w(BURST_CYCLES)-1:0]     cycle_idx
);
    localparam int CW = cnt_w(PERIOD_TICKS);
    localparam int IW = cnt_w(BURST_CYCLES);

    logic          trig_rise;
    logic          tmr_run;
    logic          tmr_restart;
    logic [IW-1:0] tmr_idx;
    logic [CW-1:0] tmr_cnt;
    burst_mode_e   burst_mode;
    logic          os_active;
    logic [CW-1:0] os_tick;
    logic          carrier_hi;
    logic          pulse_level;
    logic          gated_level;

    tbp_sync_edge u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    tbp_interval_timer #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .BURST_CYCLES (BURST_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (trig_rise),
        .mode_in (mode_sel),
        .run     (tmr_run),
        .restart (tmr_restart),
        .idx     (tmr_idx),
        .mode_q  (burst_mode),
        .cnt     (tmr_cnt)
    );

    tbp_oneshot #(
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_oneshot (
        .clk    (clk),
        .rst    (rst),
        .go     (trig_rise | tmr_restart),
        .active (os_active),
        .tick   (os_tick)
    );

    tbp_carrier #(
        .CARRIER_TICKS (CARRIER_TICKS)
    ) u_carrier (
        .clk        (clk),
        .rst        (rst),
        .align      (trig_rise),
        .carrier_hi (carrier_hi)
    );

    assign pulse_level = os_active && (int'(os_tick) < HIGH_TICKS);
    assign gated_level = os_active && (tmr_idx == '0) && carrier_hi;

    always_comb begin
        case (burst_mode)
            MODE_GATED: pwm_out = gated_level;
            default:    pwm_out = pulse_level;
        endcase
    end

    assign busy      = tmr_run;
    assign cycle_idx = tmr_idx;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !pwm_out));

    // R4
    restart_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_restart |-> (os_active && os_tick == tmr_cnt));

    // R7
    gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_mode == MODE_GATED && tmr_idx != '0) |-> !pwm_out);

    // R5
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        busy == os_active);

endmodule

// File: tb/trig_burst_pwm_tb.sv
module trig_burst_pwm_tb;

    localparam int P = 40;
    localparam int H = 15;
    localparam int C = 6;
    localparam int B = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_in = 1'b0;
    logic mode_sel = 1'b0;
    logic pwm_out;
    logic busy;
    logic [0:0] cycle_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] d_hist = '0;
    logic       m_prev = 1'b0;
    bit  m_act = 1'b0;
    int  m_n = 0;
    logic m_mode = 1'b0;
    string phase_tag = "";

    always #2 clk = ~clk;

    trig_burst_pwm #(
        .PERIOD_TICKS (P),
        .HIGH_TICKS   (H),
        .CARRIER_TICKS(C),
        .BURST_CYCLES (B)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .mode_sel  (mode_sel),
        .pwm_out   (pwm_out),
        .busy      (busy),
        .cycle_idx (cycle_idx)
    );

    function automatic logic exp_pwm(bit act, int n, logic md);
        if (!act) return 1'b0;
        if (md) return (n < P) && ((n % C) < C / 2);
        return (n % P) < H;
    endfunction

    task automatic check1(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d (n=%0d)", tag, what, act, exp, m_n);
        end
    endtask

    task automatic step(input logic tv, input logic mv);
        bit start;
        bit abort;
        string ptag;
        @(negedge clk);
        start = d_hist[2] && !d_hist[3];
        abort = start && m_act;
        if (start) begin
            m_act  = 1'b1;
            m_n    = 0;
            m_mode = m_prev;
        end else if (m_act) begin
            m_n++;
            if (m_n >= B * P) begin
                m_act = 1'b0;
                m_n   = 0;
            end
        end
        if (phase_tag != "")      ptag = phase_tag;
        else if (abort)           ptag = "R8";
        else if (start)           ptag = "R2";
        else if (m_act && m_n == P) ptag = "R4";
        else if (m_mode)          ptag = "R7";
        else                      ptag = "R3";
        check1(ptag, "pwm_out", int'(pwm_out), int'(exp_pwm(m_act, m_n, m_mode)));
        check1(start ? "R2" : "R5", "busy", int'(busy), int'(m_act));
        check1("R6", "cycle_idx", int'(cycle_idx), m_act ? m_n / P : 0);
        d_hist   = {d_hist[2:0], tv};
        m_prev   = mv;
        trig_in  = tv;
        mode_sel = mv;
    endtask

    task automatic idle(input int cycles, input logic mv);
        for (int i = 0; i < cycles; i++) step(1'b0, mv);
    endtask

    task automatic pulse(input int width, input logic mv);
        for (int i = 0; i < width; i++) step(1'b1, mv);
    endtask

    initial begin
        void'($urandom(32'd7301));
        // R1: outputs idle during and right after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check1("R1", "pwm_out", int'(pwm_out), 0);
            check1("R1", "busy", int'(busy), 0);
            check1("R1", "cycle_idx", int'(cycle_idx), 0);
        end
        rst = 1'b0;
        idle(5, 1'b0);

        // R3 R4 R5 R6: single pulse-mode burst
        pulse(2, 1'b0);
        idle(2 * P + 20, 1'b0);

        // R7: single gated-mode burst
        pulse(1, 1'b1);
        idle(2 * P + 20, 1'b1);

        // R8: retrigger in first and in second period
        pulse(2, 1'b0);
        idle(25, 1'b0);
        pulse(1, 1'b0);
        idle(P + 10, 1'b0);
        pulse(3, 1'b1);
        idle(2 * P + 20, 1'b1);

        // R9: mode flips during a burst are ignored
        phase_tag = "R9";
        pulse(1, 1'b0);
        for (int i = 0; i < 2 * P + 10; i++) step(1'b0, i[0]);
        pulse(1, 1'b1);
        idle(3, 1'b1);
        idle(2 * P + 10, 1'b0);

        // R10: trigger held high starts only one burst
        phase_tag = "R10";
        pulse(3 * P, 1'b0);
        idle(2 * P, 1'b0);
        phase_tag = "";

        // R4: retrigger lands near the burst end
        pulse(1, 1'b0);
        idle(2 * P - 3, 1'b0);
        pulse(1, 1'b1);
        idle(2 * P + 10, 1'b0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic mv;
            mv = logic'($urandom_range(0, 1));
            pulse(int'($urandom_range(1, 6)), mv);
            idle(int'($urandom_range(1, 120)), logic'($urandom_range(0, 1)));
        end
        idle(2 * P + 5, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule